// File: doc/BRIEF.md
# Iterative Step Divider

This block performs unsigned division of a 32-bit dividend by a 16-bit divisor using one compare-subtract-shift pass per clock. A one-cycle `start` pulse, sampled while the unit is idle, captures the dividend as two 16-bit halves and the divisor. The upper half becomes the working partial remainder and the lower half becomes the working quotient register.

Each pass compares the partial remainder with the divisor and subtracts when the divisor fits. It then shifts the remainder and quotient registers left as one pair, and the comparison result enters the quotient LSB. The first pass uses the plain no-borrow result. Every later pass extends the comparison with the bit that the previous shift pushed out of the remainder register. The final pass shifts only the quotient register, so the remainder stays in place.

Setup and wrap-up cycles surround the passes, which makes the latency fixed. A single-cycle `done` marks completion. The quotient and remainder stay visible on their ports until the next accepted `start`.

Top module: `step_divider`

## Requirements
- R1: After reset, `busy`, `done`, `quotient` and `remainder` are all zero.
- R2: A `start` sampled high while `busy` is low is accepted. `dividend_hi` is bits 31:16 of the dividend, `dividend_lo` is bits 15:0, and `divisor` is the divisor. `busy` is high in the cycle after the accepting edge.
- R3: `done` is high in the cycle after the 21st clock edge following the accepting edge, counting the accepting edge as zero. `busy` is low in that cycle and high in every cycle before it from acceptance onwards.
- R4: `done` is high for exactly one cycle per operation.
- R5: When `dividend_hi < divisor`, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor at `done`.
- R6: Rule R5 also holds for divisors of 0x8000 and above, where a partial remainder exceeds 16 bits between passes. Example: 0xFFFEFFFF / 0xFFFF gives quotient 0xFFFF and remainder 0xFFFE.
- R7: When `divisor <= dividend_hi < 2*divisor`, `quotient` equals the low 16 bits of the true quotient and `remainder` is the exact remainder.
- R8: A `start` sampled while `busy` is high is ignored. The running operation finishes with its own timing and its own result.
- R9: While idle with `start` low, `quotient` and `remainder` do not change, even if the operand inputs change.
- R10: A `start` sampled in the same cycle that `done` is high is accepted, and a new operation begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a divide |
| dividend_hi | input | 16 | Upper half of the dividend |
| dividend_lo | input | 16 | Lower half of the dividend |
| divisor | input | 16 | Divisor |
| quotient | output | 16 | Quotient (working low register) |
| remainder | output | 16 | Remainder (working high register) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a partial remainder that needs a seventeenth bit in the middle of the passes. This only happens when the divisor has its top bit set and the upper dividend half is just below or above it. Vectors with divisors 0xFFFF, 0x8001 and 0x8000, paired with large upper halves, force that carry bit to decide quotient bits. A second hard case is a request arriving mid-operation or in the completion cycle. Directed tests place `start` at those exact cycles and check that the timing and result match the first operation or the second, as appropriate.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STEP,
    PH_WRAP
  } phase_e;

  // one pass per quotient bit plus the leading overflow compare
  function automatic int unsigned pass_count(input int unsigned width);
    return width + 1;
  endfunction

endpackage

// File: rtl/stepdiv_ctrl.sv
module stepdiv_ctrl
  import stepdiv_pkg::*;
#(
  parameter int unsigned PASSES = 17,
  parameter int unsigned LAT    = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic done,
  output logic step_en,
  output logic pass_first,
  output logic pass_last
);

  localparam int unsigned CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;
  phase_e        phase;
  logic          finish;

  assign accept = start && !busy;
  assign finish = busy && (cnt == CW'(LAT - 1));

  always_comb begin
    if (!busy)                     phase = PH_IDLE;
    else if (cnt == '0)            phase = PH_SETUP;
    else if (cnt <= CW'(PASSES))   phase = PH_STEP;
    else                           phase = PH_WRAP;
  end

  assign step_en    = (phase == PH_STEP);
  assign pass_first = step_en && (cnt == CW'(1));
  assign pass_last  = step_en && (cnt == CW'(PASSES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/stepdiv_dp.sv
module stepdiv_dp #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step_en,
  input  logic         pass_first,
  input  logic         pass_last,
  input  logic [W-1:0] in_hi,
  input  logic [W-1:0] in_lo,
  input  logic [W-1:0] in_dv,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);

  typedef struct packed {
    logic [W-1:0] hi;
    logic [W-1:0] lo;
    logic         cy;
  } step_t;

  logic [W-1:0] dv_q;
  logic         cy_q;
  step_t        nxt;

  // one compare/subtract/shift pass
  function automatic step_t pass_fn(
    input logic [W-1:0] hi,
    input logic [W-1:0] lo,
    input logic [W-1:0] dv,
    input logic         cy,
    input logic         first,
    input logic         last
  );
    step_t        r;
    logic [W:0]   wide;
    logic [W:0]   diff;
    logic         fits;
    logic [W-1:0] rem;
    wide = {cy & ~first, hi};
    fits = (wide >= {1'b0, dv});
    diff = wide - {1'b0, dv};
    rem  = fits ? diff[W-1:0] : hi;
    r.lo = {lo[W-2:0], fits};
    if (last) begin
      r.hi = rem;
      r.cy = 1'b0;
    end else begin
      r.hi = {rem[W-2:0], lo[W-1]};
      r.cy = rem[W-1];
    end
    return r;
  endfunction

  assign nxt = pass_fn(hi_q, lo_q, dv_q, cy_q, pass_first, pass_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      dv_q <= '0;
      cy_q <= 1'b0;
    end else if (load) begin
      hi_q <= in_hi;
      lo_q <= in_lo;
      dv_q <= in_dv;
      cy_q <= 1'b0;
    end else if (step_en) begin
      hi_q <= nxt.hi;
      lo_q <= nxt.lo;
      cy_q <= nxt.cy;
    end
  end

endmodule

// File: rtl/step_divider.sv
module step_divider
  import stepdiv_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned LAT = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend_hi,
  input  logic [W-1:0] dividend_lo,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         busy,
  output logic         done
);

  localparam int unsigned PASSES = pass_count(W);

  logic accept;
  logic step_en;
  logic pass_first;
  logic pass_last;

  generate
    if (LAT < PASSES + 2) begin : g_bad_lat
      $error("LAT too small for the number of passes");
    end
  endgenerate

  stepdiv_ctrl #(
    .PASSES(PASSES),
    .LAT   (LAT)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept),
    .busy      (busy),
    .done      (done),
    .step_en   (step_en),
    .pass_first(pass_first),
    .pass_last (pass_last)
  );

  stepdiv_dp #(
    .W(W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .step_en   (step_en),
    .pass_first(pass_first),
    .pass_last (pass_last),
    .in_hi     (dividend_hi),
    .in_lo     (dividend_lo),
    .in_dv     (divisor),
    .hi_q      (remainder),
    .lo_q      (quotient)
  );

endmodule

// File: rtl/step_divider_chk.sv
module step_divider_chk #(
  parameter int unsigned W   = 16,
  parameter int unsigned LAT = 21
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         step_en,
  input logic         pass_first,
  input logic         pass_last
);

  localparam int unsigned CW = $clog2(LAT + 2);

  logic [CW-1:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lat_cnt <= '0;
    else if (start && !busy) lat_cnt <= '0;
    else if (busy)           lat_cnt <= lat_cnt + CW'(1);
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == CW'(LAT)) && !busy);

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R8
  stay_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (lat_cnt < CW'(LAT - 1))) |=> busy);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));

  // R3
  step_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> busy && !done);

  // R6
  pass_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_last |=> !step_en);

  // R2
  first_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_first |-> $past(busy) && (lat_cnt == CW'(1)));

endmodule

bind step_divider step_divider_chk #(.W(W), .LAT(LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder),
  .step_en   (step_en),
  .pass_first(pass_first),
  .pass_last (pass_last)
);

// File: tb/step_divider_test.sv
module step_divider_test;

  localparam int PERIOD = 10;
  localparam int LAT    = 21;
  localparam int NVEC   = 10;

  // {dividend[31:0], divisor, quotient, remainder, req class}
  localparam logic [83:0] VEC [NVEC] = '{
    {32'h0000_0064, 16'h0007, 16'h000E, 16'h0002, 4'd5},
    {32'h0001_0000, 16'h0002, 16'h8000, 16'h0000, 4'd5},
    {32'h0000_FFFF, 16'h0001, 16'hFFFF, 16'h0000, 4'd5},
    {32'h1234_5678, 16'h4000, 16'h48D1, 16'h1678, 4'd5},
    {32'h0000_0000, 16'h0005, 16'h0000, 16'h0000, 4'd5},
    {32'h0000_0007, 16'h0007, 16'h0001, 16'h0000, 4'd5},
    {32'hFFFE_FFFF, 16'hFFFF, 16'hFFFF, 16'hFFFE, 4'd6},
    {32'h8000_0000, 16'h8001, 16'hFFFE, 16'h0002, 4'd6},
    {32'h0003_0001, 16'h0002, 16'h8000, 16'h0001, 4'd7},
    {32'hC000_0000, 16'h8000, 16'h8000, 16'h0000, 4'd7}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] dividend_hi = '0;
  logic [15:0] dividend_lo = '0;
  logic [15:0] divisor = '0;
  logic [15:0] quotient;
  logic [15:0] remainder;
  logic        busy;
  logic        done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  step_divider uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dividend_hi(dividend_hi),
    .dividend_lo(dividend_lo),
    .divisor    (divisor),
    .quotient   (quotient),
    .remainder  (remainder),
    .busy       (busy),
    .done       (done)
  );

  always #(PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog: run hung actual=%0d expected<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // pulse start at a negedge; returns at the negedge after the accepting edge
  task automatic issue(input logic [31:0] dd, input logic [15:0] dv);
    @(negedge clk);
    start       = 1'b1;
    dividend_hi = dd[31:16];
    dividend_lo = dd[15:0];
    divisor     = dv;
    @(negedge clk);
    start = 1'b0;
  endtask

  // counts edges after acceptance until done is seen
  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic string rq(input logic [3:0] c);
    case (c)
      4'd6:    return "R6";
      4'd7:    return "R7";
      default: return "R5";
    endcase
  endfunction

  initial begin
    int n;
    logic [15:0] hq, hr;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1", "busy/done at reset", {busy, done}, 0);
    chk(quotient == 0 && remainder == 0, "R1", "results at reset",
        {quotient, remainder}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][83:52], VEC[i][51:36]);
      chk(busy, "R2", "busy after accept", busy, 1);
      wait_done(n);
      chk(n == LAT, "R3", "latency", n, LAT);
      chk(!busy, "R3", "busy low with done", busy, 0);
      chk(quotient == VEC[i][35:20], rq(VEC[i][3:0]), "quotient",
          quotient, VEC[i][35:20]);
      chk(remainder == VEC[i][19:4], rq(VEC[i][3:0]), "remainder",
          remainder, VEC[i][19:4]);
      @(negedge clk);
      chk(!done, "R4", "done width", done, 0);
    end

    // R8: second start mid-run is ignored
    issue(32'h0000_0064, 16'h0007);
    repeat (5) @(negedge clk);
    start = 1'b1; dividend_hi = 16'h0000; dividend_lo = 16'h0009; divisor = 16'h0002;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    chk(n == LAT - 6, "R8", "remaining latency", n, LAT - 6);
    chk(quotient == 16'h000E && remainder == 16'h0002, "R8", "result kept",
        {quotient, remainder}, {16'h000E, 16'h0002});

    // R10: start in the done cycle is accepted
    start = 1'b1; dividend_hi = 16'h0000; dividend_lo = 16'h0009; divisor = 16'h0002;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R10", "busy after start in done cycle", busy, 1);
    wait_done(n);
    chk(n == LAT, "R10", "latency of second op", n, LAT);
    chk(quotient == 16'h0004 && remainder == 16'h0001, "R10", "second result",
        {quotient, remainder}, {16'h0004, 16'h0001});

    // R9: idle outputs hold while operand inputs move
    hq = quotient; hr = remainder;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      dividend_hi = 16'(k * 3); dividend_lo = 16'(k * 7 + 1); divisor = 16'(k + 1);
    end
    @(negedge clk);
    chk(quotient == hq && remainder == hr && !busy, "R9", "idle hold",
        {quotient, remainder}, {hq, hr});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule